// File: doc/BRIEF.md
# Programmable Interval Down-Counter

This block is a single down-counting interval timer with a small word-addressed register port. Software picks a counting mode and a counter width, a tick divider and an interrupt mask through a control byte. The counter then decrements on prescaled pulses of a shared tick-enable input. It raises a level interrupt each time the count arrives at zero. There are three counting modes. Free-running wraps at the full range of the selected width. Periodic reloads a programmed value on every wrap. One-shot halts once it reaches zero.

The reload value can be changed in two ways. The first restarts the count at once. The second, a background update, only replaces the value used at the next wrap. Interrupt status is visible both raw and gated by the enable bit, and a write-only strobe clears it. The core is a three-state machine. `ST_OFF` means counting is disabled. `ST_RUN` means it is counting. `ST_SPENT` means a one-shot has expired. Its transitions are:

- T_ARM: a control write with the enable bit set, or a load write while enabled, moves to `ST_RUN` from any state.
- T_HALT: a control write with the enable bit clear, or a load write while disabled, moves to `ST_OFF` from any state.
- T_EXPIRE: in `ST_RUN` with one-shot selected, the counting pulse that moves the count from 1 to 0 moves to `ST_SPENT`.

Top module: `intv_timer`

## Requirements
- R1: After reset, control reads 0x20 (interrupt enable only: disabled, free-running, 16-bit, divide by 1). Load, value and raw status read 0, and `irq` is low.
- R2: The control byte has these fields: bit 7 enable, bit 6 periodic, bit 5 interrupt enable, bits 3:2 divider, bit 1 32-bit width, bit 0 one-shot. Divider code 0 passes every `tick_en`, 1 passes one in 16, 2 passes one in 256, and 3 acts as code 0. A control write restarts the divider phase. The count changes only on a passed pulse while in `ST_RUN`.
- R3: Word offsets are 0 for load, 1 for value, 2 for control, 3 for clear, 4 for raw, 5 for masked and 6 for background load. A write at offset 0 stores the reload value and sets the count to the mode's reload value in the same cycle. Offsets 0 and 6 both read back the stored reload value.
- R4: A write at offset 6 changes the stored reload value only. The running count carries on and picks up the new value at its next wrap.
- R5: When bits 6 and 0 are both clear, the reload value is 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode, whatever is stored at offset 0.
- R6: A counting pulse seen at a count of 0 reloads in periodic and free-running modes. In one-shot mode the count stays at 0 after expiry (T_EXPIRE) until the next load or control write.
- R7: In 16-bit mode only the low 16 bits count, and the value register reads zero in bits 31:16.
- R8: Raw status (offset 4, bit 0) sets on the counting pulse that moves the count from 1 to 0. A write at offset 3 clears it. If both happen in the same cycle, the set wins.
- R9: Masked status (offset 5) and `irq` both equal raw status AND control bit 5.
- R10: Writes at offset 1 and at offset 7 change nothing. Reads at offsets 3 and 7 return zero.
- R11: A control write with bit 7 set reloads the count from the reload value of the new mode. A control write with bit 7 clear leaves the count as it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Shared counting pulse before division |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 3 | Word offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach from the ports are collisions. One is a clear strobe landing in the same cycle as the zero event. Another is a one-shot that keeps receiving pulses after it has expired. A third is the last pulse before a divide-by-256 boundary. Directed sequences set up each of these with exact pulse counts. A long seeded random phase follows. It keeps reload values small so that wraps, expiries and background updates happen often, and it changes the mode randomly while the counter is running. Every register is compared against a bench model after every cycle.

// File: rtl/intv_pkg.sv
package intv_pkg;
    localparam int CTRL_W = 8;
    localparam int OFS_W  = 3;

    localparam int B_ONESHOT  = 0;
    localparam int B_WIDE     = 1;
    localparam int B_PRE_LO   = 2;
    localparam int B_IE       = 5;
    localparam int B_PERIODIC = 6;
    localparam int B_EN       = 7;

    localparam logic [CTRL_W-1:0] CTRL_RST = 8'h20;

    localparam logic [OFS_W-1:0] OFS_LOAD   = 3'd0;
    localparam logic [OFS_W-1:0] OFS_VALUE  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd2;
    localparam logic [OFS_W-1:0] OFS_CLR    = 3'd3;
    localparam logic [OFS_W-1:0] OFS_RAW    = 3'd4;
    localparam logic [OFS_W-1:0] OFS_MASKED = 3'd5;
    localparam logic [OFS_W-1:0] OFS_BG     = 3'd6;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_SPENT = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        PRE_1    = 2'd0,
        PRE_16   = 2'd1,
        PRE_256  = 2'd2,
        PRE_RSVD = 2'd3
    } pre_code_e;
endpackage

// File: rtl/intv_prescale.sv
module intv_prescale
    import intv_pkg::*;
#(
    parameter int SHIFT_A = 4,
    parameter int SHIFT_B = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       restart,
    input  logic [1:0] code,
    output logic       ptick
);
    localparam int PRE_W = SHIFT_B;

    logic [PRE_W-1:0] pre_q;
    logic             hit;

    // Phase counter of raw ticks; a control write restarts the phase.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else if (tick_en) pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        unique case (pre_code_e'(code))
            PRE_16:  hit = &pre_q[SHIFT_A-1:0];
            PRE_256: hit = &pre_q;
            default: hit = 1'b1;
        endcase
    end

    assign ptick = tick_en & hit;
endmodule

// File: rtl/intv_core.sv
module intv_core
    import intv_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_q,
    input  logic [CNT_W-1:0]  load_q,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              ld_wr,
    input  logic              ctrl_wr,
    input  logic              ptick,
    output logic [CNT_W-1:0]  cnt_view,
    output logic              zero_evt,
    output run_state_e        state_o
);
    localparam int HALF_W = CNT_W / 2;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    function automatic logic [CNT_W-1:0] width_mask(input logic [CTRL_W-1:0] c);
        return c[B_WIDE] ? {CNT_W{1'b1}} : {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    endfunction

    function automatic logic [CNT_W-1:0] reload_of(input logic [CTRL_W-1:0] c,
                                                   input logic [CNT_W-1:0]  l);
        logic free_run;
        free_run = !c[B_PERIODIC] && !c[B_ONESHOT];
        return (free_run ? {CNT_W{1'b1}} : l) & width_mask(c);
    endfunction

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cur;
    logic             count_go, hit_one;
    logic [CTRL_W-1:0] wctrl;

    assign wctrl    = wdata[CTRL_W-1:0];
    assign cur      = cnt_q & width_mask(ctrl_q);
    assign count_go = (state_q == ST_RUN) && ptick && !ld_wr && !ctrl_wr;
    assign hit_one  = (cur == ONE);

    // State register and counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic: T_ARM, T_HALT, T_EXPIRE.
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            state_d = wctrl[B_EN] ? ST_RUN : ST_OFF;
        end else if (ld_wr) begin
            state_d = ctrl_q[B_EN] ? ST_RUN : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_OFF;
                ST_RUN:   if (count_go && hit_one && ctrl_q[B_ONESHOT]) state_d = ST_SPENT;
                ST_SPENT: state_d = ST_SPENT;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    // Outputs of the machine: next count and the zero event.
    always_comb begin
        cnt_d    = cnt_q;
        zero_evt = 1'b0;
        if (ld_wr) begin
            cnt_d = reload_of(ctrl_q, wdata);
        end else if (ctrl_wr) begin
            if (wctrl[B_EN]) cnt_d = reload_of(wctrl, load_q);
        end else if (count_go) begin
            if (cur == '0) begin
                cnt_d = reload_of(ctrl_q, load_q);
            end else begin
                cnt_d    = cur - ONE;
                zero_evt = hit_one;
            end
        end
    end

    assign cnt_view = cur;
    assign state_o  = state_q;
endmodule

// File: rtl/intv_regs.sv
module intv_regs
    import intv_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              zero_evt,
    input  logic [CNT_W-1:0]  cnt_view,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  load_q,
    output logic              raw_q,
    output logic              ld_wr,
    output logic              ctrl_wr,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);
    logic clr_wr, bg_wr;

    assign ld_wr   = wr_en && (addr == OFS_LOAD);
    assign ctrl_wr = wr_en && (addr == OFS_CTRL);
    assign clr_wr  = wr_en && (addr == OFS_CLR);
    assign bg_wr   = wr_en && (addr == OFS_BG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
            load_q <= '0;
            raw_q  <= 1'b0;
        end else begin
            if (ctrl_wr)              ctrl_q <= wdata[CTRL_W-1:0];
            if (ld_wr || bg_wr)       load_q <= wdata;
            if (zero_evt)             raw_q  <= 1'b1;
            else if (clr_wr)          raw_q  <= 1'b0;
        end
    end

    always_comb begin
        case (addr)
            OFS_LOAD, OFS_BG: rdata = load_q;
            OFS_VALUE:        rdata = cnt_view;
            OFS_CTRL:         rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
            OFS_RAW:          rdata = {{(CNT_W-1){1'b0}}, raw_q};
            OFS_MASKED:       rdata = {{(CNT_W-1){1'b0}}, raw_q & ctrl_q[B_IE]};
            default:          rdata = '0;
        endcase
    end

    assign irq = raw_q & ctrl_q[B_IE];
endmodule

// File: rtl/intv_timer.sv
module intv_timer
    import intv_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SHIFT_A = 4,
    parameter int SHIFT_B = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  load_q, cnt_view;
    logic              raw_q, ld_wr, ctrl_wr, ptick, zero_evt;
    run_state_e        run_state;

    intv_prescale #(.SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .restart (ctrl_wr),
        .code    (ctrl_q[B_PRE_LO+1:B_PRE_LO]),
        .ptick   (ptick)
    );

    intv_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_q   (ctrl_q),
        .load_q   (load_q),
        .wdata    (wdata),
        .ld_wr    (ld_wr),
        .ctrl_wr  (ctrl_wr),
        .ptick    (ptick),
        .cnt_view (cnt_view),
        .zero_evt (zero_evt),
        .state_o  (run_state)
    );

    intv_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .zero_evt (zero_evt),
        .cnt_view (cnt_view),
        .ctrl_q   (ctrl_q),
        .load_q   (load_q),
        .raw_q    (raw_q),
        .ld_wr    (ld_wr),
        .ctrl_wr  (ctrl_wr),
        .rdata    (rdata),
        .irq      (irq)
    );
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk
    import intv_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [OFS_W-1:0]  addr,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              raw_q,
    input logic              irq,
    input logic              ptick,
    input logic              zero_evt,
    input run_state_e        run_state,
    input logic [CNT_W-1:0]  cnt_view
);
    localparam logic [OFS_W-1:0] OFS_HOLE = {OFS_W{1'b1}};

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptick && !wr_en) |=> $stable(cnt_view));

    p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_OFF) |-> !ctrl_q[B_EN]);

    p_bg_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_BG && !ptick) |=> $stable(cnt_view));

    p_spent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_SPENT && !wr_en) |=> (run_state == ST_SPENT) && $stable(cnt_view));

    p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> raw_q);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CLR && !zero_evt) |=> !raw_q);

    p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[B_IE] |-> !irq);

    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_VALUE || addr == OFS_HOLE) && !ptick)
        |=> $stable(cnt_view) && $stable(ctrl_q));
endmodule

bind intv_timer intv_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .ctrl_q    (ctrl_q),
    .raw_q     (raw_q),
    .irq       (irq),
    .ptick     (ptick),
    .zero_evt  (zero_evt),
    .run_state (run_state),
    .cnt_view  (cnt_view)
);

// File: tb/tb_intv_timer.sv
`timescale 1ns/100ps
module tb_intv_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int bad = 0;

    logic [7:0]  m_ctrl;
    logic [31:0] m_load, m_cnt;
    logic        m_raw, m_spent;
    logic [7:0]  m_pre;

    always #4 clk = ~clk;

    intv_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] fmask(input logic [7:0] c);
        return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] frel(input logic [7:0] c, input logic [31:0] l);
        return ((c[6] || c[0]) ? l : 32'hFFFF_FFFF) & fmask(c);
    endfunction

    function automatic logic pre_hit(input logic [7:0] c, input logic [7:0] p);
        case (c[3:2])
            2'd1:    return &p[3:0];
            2'd2:    return &p;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #0.5;
        chk(tag, rdata, exp);
    endtask

    task automatic check_all(input string tag);
        rd(tag, 3'd0, m_load);
        rd(tag, 3'd1, m_cnt & fmask(m_ctrl));
        rd(tag, 3'd2, {24'd0, m_ctrl});
        rd(tag, 3'd3, 32'd0);
        rd(tag, 3'd4, {31'd0, m_raw});
        rd(tag, 3'd5, {31'd0, m_raw & m_ctrl[5]});
        rd(tag, 3'd6, m_load);
        rd(tag, 3'd7, 32'd0);
        chk(tag, {31'd0, irq}, {31'd0, m_raw & m_ctrl[5]});
    endtask

    task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d, input logic t);
        logic pt, set_e, clr_e, blk;
        logic [31:0] c;
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; tick_en = t;
        @(posedge clk);
        pt    = t && pre_hit(m_ctrl, m_pre);
        set_e = 1'b0;
        clr_e = w && a == 3'd3;
        blk   = w && (a == 3'd0 || a == 3'd2);
        c     = m_cnt & fmask(m_ctrl);
        if (!blk && m_ctrl[7] && !m_spent && pt) begin
            if (c == 32'd0) m_cnt = frel(m_ctrl, m_load);
            else begin
                m_cnt = c - 32'd1;
                if (c == 32'd1) begin
                    set_e = 1'b1;
                    if (m_ctrl[0]) m_spent = 1'b1;
                end
            end
        end
        if (w && a == 3'd0) begin m_load = d; m_cnt = frel(m_ctrl, d); m_spent = 1'b0; end
        if (w && a == 3'd2) begin
            m_ctrl = d[7:0]; m_spent = 1'b0;
            if (d[7]) m_cnt = frel(d[7:0], m_load);
        end
        if (w && a == 3'd6) m_load = d;
        if (w && a == 3'd2) m_pre = 8'd0;
        else if (t)         m_pre = m_pre + 8'd1;
        m_raw = set_e ? 1'b1 : (clr_e ? 1'b0 : m_raw);
        #1;
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0, 1'b1);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        m_ctrl = 8'h20; m_load = 0; m_cnt = 0; m_raw = 0; m_spent = 0; m_pre = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check_all("R1");
        rd("R1", 3'd2, 32'h20);

        // R5/R7 free-running 16-bit
        step(1, 3'd2, 32'hA0, 0);
        rd("R5", 3'd1, 32'h0000_FFFF);
        ticks(3);
        rd("R7", 3'd1, 32'h0000_FFFC);
        check_all("R7");
        step(1, 3'd2, 32'hA2, 0);
        rd("R5", 3'd1, 32'hFFFF_FFFF);

        // R11 disable holds, R3 load reloads, R6/R8/R9 periodic wrap
        step(1, 3'd2, 32'h60, 0);
        rd("R11", 3'd1, 32'h0000_FFFF);
        step(1, 3'd0, 32'd3, 0);
        rd("R3", 3'd1, 32'd3);
        step(1, 3'd2, 32'hE2, 0);
        ticks(3);
        rd("R8", 3'd4, 32'd1);
        chk("R9", {31'd0, irq}, 32'd1);
        ticks(1);
        rd("R6", 3'd1, 32'd3);
        step(1, 3'd3, 32'd0, 0);
        rd("R8", 3'd4, 32'd0);

        // R4 background load
        step(1, 3'd6, 32'd10, 0);
        rd("R4", 3'd1, 32'd3);
        rd("R3", 3'd0, 32'd10);
        rd("R3", 3'd6, 32'd10);
        ticks(3);
        rd("R4", 3'd1, 32'd0);
        ticks(1);
        rd("R4", 3'd1, 32'd10);
        step(1, 3'd3, 32'd0, 0);

        // R6 one-shot expiry
        step(1, 3'd0, 32'd2, 0);
        step(1, 3'd2, 32'hA3, 0);
        rd("R11", 3'd1, 32'd2);
        ticks(5);
        rd("R6", 3'd1, 32'd0);
        rd("R8", 3'd4, 32'd1);
        check_all("R6");
        step(1, 3'd3, 32'd0, 0);

        // R2 divide by 16 and by 256
        step(1, 3'd0, 32'd100, 0);
        step(1, 3'd2, 32'hE6, 0);
        ticks(15);
        rd("R2", 3'd1, 32'd100);
        ticks(1);
        rd("R2", 3'd1, 32'd99);
        step(1, 3'd2, 32'hEA, 0);
        ticks(255);
        rd("R2", 3'd1, 32'd100);
        ticks(1);
        rd("R2", 3'd1, 32'd99);

        // R9 mask with raw set
        step(1, 3'd2, 32'hE2, 0);
        step(1, 3'd0, 32'd1, 0);
        ticks(1);
        step(1, 3'd2, 32'hC2, 0);
        rd("R9", 3'd4, 32'd1);
        rd("R9", 3'd5, 32'd0);
        chk("R9", {31'd0, irq}, 32'd0);

        // R10 ignored writes and empty offsets
        step(1, 3'd1, 32'h1234, 0);
        rd("R10", 3'd1, 32'd1);
        step(1, 3'd7, 32'hFFFF_FFFF, 0);
        rd("R10", 3'd7, 32'd0);
        rd("R10", 3'd3, 32'd0);
        rd("R10", 3'd2, 32'hC2);
        rd("R10", 3'd0, 32'd1);

        // R8 set wins over simultaneous clear
        step(1, 3'd3, 32'd0, 0);
        step(1, 3'd3, 32'd0, 1);
        rd("R8", 3'd4, 32'd1);
        check_all("R8");

        // Seeded random phase
        begin
            int unsigned seed_dummy;
            seed_dummy = $urandom(32'h5EED);
        end
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom % 16;
            case (r)
                0: step(1, 3'd0, ($urandom % 4 == 0) ? $urandom : ($urandom % 24), $urandom % 2);
                1: step(1, 3'd2, {24'd0, ($urandom % 4 != 0), 7'($urandom & 32'h6F)}, $urandom % 2);
                2: step(1, 3'd3, 32'd0, $urandom % 2);
                3: step(1, 3'd6, $urandom % 24, $urandom % 2);
                4: step(1, ($urandom % 2) ? 3'd1 : 3'd7, $urandom, $urandom % 2);
                default: step(0, 3'd0, 32'd0, 1);
            endcase
            check_all("R6");
        end

        finish_run();
    end
endmodule